// File: doc/BRIEF.md
# Tiny Two-Operand Register Core

A minimal 32-bit processor for a mesh of many small compute nodes. It has four 32-bit registers and 128 bytes of local memory that hold both program and data. Instructions are one byte (register form) or five bytes (an opcode byte followed by a 32-bit little-endian immediate). Every instruction spends one clock being fetched and one clock executing, and that second clock is where a memory access happens.

The core reaches the outside world only through inbound messages and three outbound request/acknowledge channels. An inbound message either writes one 32-bit word of local memory or, while the core is idle, starts execution at address 0. Sending a message, allocating another node and signalling termination are instructions. Each raises its request with its operands and holds it until the environment acknowledges. A receive instruction waits until enough inbound store messages have arrived since the start.

Top module: `tiny_core`

## Requirements
- R1: After reset the core is idle (`halted`=1), `err_flag`=0, no request is raised and `msg_in_ready`=1.
- R2: An accepted inbound message with `msg_in_start`=0 writes `msg_in_data` to memory word `msg_in_addr`. Word w holds bytes 4w..4w+3, least significant byte at the lowest address. A start message received while idle begins execution at byte 0. `msg_in_ready` is low only in the execute cycle of a store or a memory load.
- R3: The first instruction byte is opcode[7:4], reg1[3:2], reg2[1:0]. Opcodes are: add 0, sub 1, shl 2, shr 3, and 4, xor 5, snd 6, rcv 7, move 8, load-immediate 9, store 10, fork 11, end 12, load-memory 13. Opcodes 9 to 13 are followed by a 4-byte little-endian immediate. All other opcodes are one byte long.
- R4: add, sub, and and xor write reg1 = reg1 op reg2. move writes reg1 = reg2. shl and shr write reg1 = reg2 shifted by exactly one bit, with a zero filled in.
- R5: load-immediate writes the immediate to reg1. load-memory writes the memory word at reg2+immediate to reg1. store writes reg1 to the word at reg2+immediate. The address is taken modulo 128, and its two low bits are ignored.
- R6: Each instruction that does not stall takes exactly two cycles. The end request of an N-instruction program appears 2N-1 cycles after the cycle in which the start message is accepted.
- R7: snd raises `snd_req` with `snd_data`=reg1 and `snd_addr`=reg2. These hold steady, and the core does not advance, until `snd_ack`.
- R8: fork raises `fork_req` with `fork_data`=immediate and stalls until `fork_ack`.
- R9: end raises `end_req` with `end_data`=immediate. After `end_ack` the core is idle.
- R10: rcv takes n = {reg1,reg2} as a 4-bit constant. It stalls until at least n store messages have arrived since the start, and then consumes n of them.
- R11: Opcodes 14 and 15 stop the core: it becomes idle with `err_flag`=1. The next start clears the flag.
- R12: The program counter is 7 bits wide and wraps modulo 128. This holds both for the next instruction and for immediate bytes that run past byte 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| msg_in_valid | input | 1 | Inbound message present |
| msg_in_start | input | 1 | 1 = start message, 0 = memory store message |
| msg_in_addr | input | 5 | Target memory word |
| msg_in_data | input | 32 | Word to store |
| msg_in_ready | output | 1 | Inbound message can be taken this cycle |
| snd_req | output | 1 | Send request |
| snd_data | output | 32 | Send payload (reg1) |
| snd_addr | output | 32 | Send destination (reg2) |
| snd_ack | input | 1 | Send acknowledged |
| fork_req | output | 1 | Allocation request |
| fork_data | output | 32 | Allocation operand (immediate) |
| fork_ack | input | 1 | Allocation acknowledged |
| end_req | output | 1 | Termination request |
| end_data | output | 32 | Termination operand (immediate) |
| end_ack | input | 1 | Termination acknowledged |
| halted | output | 1 | Core idle |
| err_flag | output | 1 | Stopped on an undefined opcode |

## Verification
The ALU program uses operands whose top bits differ. This separates add from sub, shows carry-out being dropped, and makes the one-bit shifts lose the MSB or the LSB, so a wrong shift amount or fill bit is visible. A load/store program uses an unaligned displacement and one that is past 128, which exposes address-wrap and lane-select mistakes. It also counts the cycles in which inbound messages are blocked. Receive is tried with messages arriving both before and during the wait, which checks that counts are consumed correctly. A program that fills all 128 bytes, with a long instruction at the last byte, checks that the program counter and the immediate fetch both wrap.

// File: rtl/tc_pkg.sv
package tc_pkg;
   typedef enum logic [3:0] {
      OP_ADD   = 4'd0,  OP_SUB   = 4'd1,  OP_SHL  = 4'd2,  OP_SHR = 4'd3,
      OP_AND   = 4'd4,  OP_XOR   = 4'd5,  OP_SND  = 4'd6,  OP_RCV = 4'd7,
      OP_MOVE  = 4'd8,  OP_LDI   = 4'd9,  OP_STORE = 4'd10, OP_FORK = 4'd11,
      OP_END   = 4'd12, OP_LDM   = 4'd13, OP_UND14 = 4'd14, OP_UND15 = 4'd15
   } op_e;

   typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_EXEC} state_e;

   function automatic logic op_is_long(op_e op);
      return op inside {OP_LDI, OP_STORE, OP_FORK, OP_END, OP_LDM};
   endfunction
endpackage

// File: rtl/tc_regfile.sv
module tc_regfile #(
   parameter int DATA_W = 32,
   parameter int REG_N  = 4,
   localparam int SEL_W = $clog2(REG_N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  rd_a_sel,
   output logic [DATA_W-1:0] rd_a,
   input  logic [SEL_W-1:0]  rd_b_sel,
   output logic [DATA_W-1:0] rd_b,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [DATA_W-1:0] wr_data
);
   logic [DATA_W-1:0] regs_q [REG_N];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < REG_N; i++) regs_q[i] <= '0;
      end else if (wr_en) begin
         regs_q[wr_sel] <= wr_data;
      end
   end

   assign rd_a = regs_q[rd_a_sel];
   assign rd_b = regs_q[rd_b_sel];
endmodule

// File: rtl/tc_alu.sv
module tc_alu
   import tc_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  op_e               op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y
);
   always_comb begin
      unique case (op)
         OP_ADD:  y = a + b;
         OP_SUB:  y = a - b;
         OP_SHL:  y = {b[DATA_W-2:0], 1'b0};
         OP_SHR:  y = {1'b0, b[DATA_W-1:1]};
         OP_AND:  y = a & b;
         OP_XOR:  y = a ^ b;
         OP_MOVE: y = b;
         default: y = a;
      endcase
   end
endmodule

// File: rtl/tc_mem.sv
module tc_mem #(
   parameter int DATA_W    = 32,
   parameter int MEM_BYTES = 128,
   parameter int FETCH_N   = 5,
   localparam int BPW      = DATA_W / 8,
   localparam int BSEL     = $clog2(BPW),
   localparam int PC_W     = $clog2(MEM_BYTES),
   localparam int WORDS    = MEM_BYTES / BPW,
   localparam int WADDR_W  = $clog2(WORDS)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [PC_W-1:0]              fetch_pc,
   output logic [FETCH_N-1:0][7:0]      fetch_bytes,
   input  logic [WADDR_W-1:0]           rd_waddr,
   output logic [DATA_W-1:0]            rd_data,
   input  logic                         a_we,
   input  logic [WADDR_W-1:0]           a_waddr,
   input  logic [DATA_W-1:0]            a_wdata,
   input  logic                         b_we,
   input  logic [WADDR_W-1:0]           b_waddr,
   input  logic [DATA_W-1:0]            b_wdata
);
   logic [DATA_W-1:0] words_q [WORDS];

   always_ff @(posedge clk) begin
      if (a_we)      words_q[a_waddr] <= a_wdata;
      else if (b_we) words_q[b_waddr] <= b_wdata;
   end

   assign rd_data = words_q[rd_waddr];

   for (genvar k = 0; k < FETCH_N; k++) begin : g_fetch
      logic [PC_W-1:0] baddr;
      assign baddr          = fetch_pc + PC_W'(k);
      assign fetch_bytes[k] = words_q[baddr[PC_W-1:BSEL]][baddr[BSEL-1:0]*8 +: 8];
   end

   // R2
   port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_we && b_we));
endmodule

// File: rtl/tiny_core.sv
module tiny_core
   import tc_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int MEM_BYTES = 128,
   parameter int REG_N     = 4,
   parameter int CNT_W     = 5,
   localparam int IMM_BYTES = DATA_W / 8,
   localparam int LONG_LEN  = 1 + IMM_BYTES,
   localparam int PC_W      = $clog2(MEM_BYTES),
   localparam int BSEL      = $clog2(IMM_BYTES),
   localparam int WADDR_W   = $clog2(MEM_BYTES / IMM_BYTES),
   localparam int CS_W      = CNT_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               msg_in_valid,
   input  logic               msg_in_start,
   input  logic [WADDR_W-1:0] msg_in_addr,
   input  logic [DATA_W-1:0]  msg_in_data,
   output logic               msg_in_ready,
   output logic               snd_req,
   output logic [DATA_W-1:0]  snd_data,
   output logic [DATA_W-1:0]  snd_addr,
   input  logic               snd_ack,
   output logic               fork_req,
   output logic [DATA_W-1:0]  fork_data,
   input  logic               fork_ack,
   output logic               end_req,
   output logic [DATA_W-1:0]  end_data,
   input  logic               end_ack,
   output logic               halted,
   output logic               err_flag
);
   if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_bad_width
      $error("tiny_core: DATA_W must be a multiple of 8 and at least 16");
   end
   if ((1 << PC_W) != MEM_BYTES) begin : g_bad_mem
      $error("tiny_core: MEM_BYTES must be a power of two");
   end
   if ((1 << BSEL) != IMM_BYTES) begin : g_bad_lanes
      $error("tiny_core: bytes per word must be a power of two");
   end
   if (REG_N != 4) begin : g_bad_regs
      $error("tiny_core: encoding has 2-bit register fields, REG_N must be 4");
   end
   if (CNT_W < 4) begin : g_bad_cnt
      $error("tiny_core: CNT_W must hold a 4-bit receive count");
   end

   state_e            state_q, nxt_state;
   logic [PC_W-1:0]   pc_q;
   op_e               ir_op;
   logic [1:0]        ir_r1, ir_r2;
   logic [DATA_W-1:0] ir_imm;
   logic [CNT_W-1:0]  cnt_q;

   logic [LONG_LEN-1:0][7:0] fb;
   logic [DATA_W-1:0] imm_fetch, ra, rb, alu_y, mem_rdata, rf_wdata;
   logic [WADDR_W-1:0] ea_w;
   logic              rf_we, mem_we_x, consume, done, bad, start_hit, arrive;
   logic [3:0]        rcv_n;
   logic [CS_W-1:0]   cnt_sum;
   op_e               fetch_op;

   assign fetch_op = op_e'(fb[0][7:4]);

   always_comb begin
      for (int i = 0; i < IMM_BYTES; i++) imm_fetch[8*i +: 8] = fb[i+1];
   end

   tc_mem #(.DATA_W(DATA_W), .MEM_BYTES(MEM_BYTES), .FETCH_N(LONG_LEN)) u_mem (
      .clk(clk), .rst_n(rst_n), .fetch_pc(pc_q), .fetch_bytes(fb),
      .rd_waddr(ea_w), .rd_data(mem_rdata),
      .a_we(mem_we_x), .a_waddr(ea_w), .a_wdata(ra),
      .b_we(arrive), .b_waddr(msg_in_addr), .b_wdata(msg_in_data));

   tc_regfile #(.DATA_W(DATA_W), .REG_N(REG_N)) u_rf (
      .clk(clk), .rst_n(rst_n), .rd_a_sel(ir_r1), .rd_a(ra),
      .rd_b_sel(ir_r2), .rd_b(rb), .wr_en(rf_we), .wr_sel(ir_r1),
      .wr_data(rf_wdata));

   tc_alu #(.DATA_W(DATA_W)) u_alu (.op(ir_op), .a(ra), .b(rb), .y(alu_y));

   assign ea_w  = WADDR_W'((rb[PC_W-1:0] + ir_imm[PC_W-1:0]) >> BSEL);
   assign rcv_n = {ir_r1, ir_r2};

   assign msg_in_ready = !(state_q == ST_EXEC && (ir_op == OP_STORE || ir_op == OP_LDM));
   assign start_hit    = msg_in_valid && msg_in_start && state_q == ST_IDLE;
   assign arrive       = msg_in_valid && !msg_in_start && msg_in_ready;

   always_comb begin
      nxt_state = state_q;
      done      = 1'b0;
      bad       = 1'b0;
      rf_we     = 1'b0;
      rf_wdata  = alu_y;
      mem_we_x  = 1'b0;
      consume   = 1'b0;
      snd_req   = 1'b0;
      fork_req  = 1'b0;
      end_req   = 1'b0;
      unique case (state_q)
         ST_IDLE:  if (start_hit) nxt_state = ST_FETCH;
         ST_FETCH: nxt_state = ST_EXEC;
         ST_EXEC: begin
            unique case (ir_op)
               OP_ADD, OP_SUB, OP_SHL, OP_SHR, OP_AND, OP_XOR, OP_MOVE: begin
                  rf_we = 1'b1;
                  done  = 1'b1;
               end
               OP_SND: begin
                  snd_req = 1'b1;
                  done    = snd_ack;
               end
               OP_RCV: begin
                  if (cnt_q >= CNT_W'(rcv_n)) begin
                     consume = 1'b1;
                     done    = 1'b1;
                  end
               end
               OP_LDI: begin
                  rf_we    = 1'b1;
                  rf_wdata = ir_imm;
                  done     = 1'b1;
               end
               OP_LDM: begin
                  rf_we    = 1'b1;
                  rf_wdata = mem_rdata;
                  done     = 1'b1;
               end
               OP_STORE: begin
                  mem_we_x = 1'b1;
                  done     = 1'b1;
               end
               OP_FORK: begin
                  fork_req = 1'b1;
                  done     = fork_ack;
               end
               OP_END: begin
                  end_req = 1'b1;
                  if (end_ack) nxt_state = ST_IDLE;
               end
               default: begin
                  bad       = 1'b1;
                  nxt_state = ST_IDLE;
               end
            endcase
            if (done) nxt_state = ST_FETCH;
         end
         default: nxt_state = ST_IDLE;
      endcase
   end

   assign cnt_sum = {1'b0, cnt_q} - (consume ? CS_W'(rcv_n) : '0) + CS_W'(arrive);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         pc_q     <= '0;
         ir_op    <= OP_ADD;
         ir_r1    <= '0;
         ir_r2    <= '0;
         ir_imm   <= '0;
         err_flag <= 1'b0;
         cnt_q    <= '0;
      end else begin
         state_q <= nxt_state;
         if (start_hit) begin
            pc_q     <= '0;
            err_flag <= 1'b0;
            cnt_q    <= '0;
         end else begin
            cnt_q <= cnt_sum[CNT_W] ? '1 : cnt_sum[CNT_W-1:0];
         end
         if (state_q == ST_FETCH) begin
            ir_op  <= fetch_op;
            ir_r1  <= fb[0][3:2];
            ir_r2  <= fb[0][1:0];
            ir_imm <= imm_fetch;
            pc_q   <= pc_q + (op_is_long(fetch_op) ? PC_W'(LONG_LEN) : PC_W'(1));
         end
         if (bad) err_flag <= 1'b1;
      end
   end

   assign snd_data  = ra;
   assign snd_addr  = rb;
   assign fork_data = ir_imm;
   assign end_data  = ir_imm;
   assign halted    = (state_q == ST_IDLE);

   // R6
   fetch_then_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_FETCH |=> state_q == ST_EXEC);
   // R7
   snd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snd_req && !snd_ack |=> snd_req && $stable(snd_data) && $stable(snd_addr));
   // R7
   one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({snd_req, fork_req, end_req}));
   // R8
   fork_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fork_req && !fork_ack |=> fork_req && $stable(fork_data));
   // R9
   end_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      end_req && end_ack |=> halted);
   // R11
   err_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |-> halted);
endmodule

// File: tb/tiny_core_bench.sv
module tiny_core_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        msg_in_valid = 1'b0, msg_in_start = 1'b0;
   logic [4:0]  msg_in_addr = '0;
   logic [31:0] msg_in_data = '0;
   logic        msg_in_ready;
   logic        snd_req, fork_req, end_req;
   logic [31:0] snd_data, snd_addr, fork_data, end_data;
   logic        snd_ack = 1'b0, fork_ack = 1'b0, end_ack = 1'b0;
   logic        halted, err_flag;

   tiny_core u_tiny_core (
      .clk(clk), .rst_n(rst_n), .msg_in_valid(msg_in_valid),
      .msg_in_start(msg_in_start), .msg_in_addr(msg_in_addr),
      .msg_in_data(msg_in_data), .msg_in_ready(msg_in_ready),
      .snd_req(snd_req), .snd_data(snd_data), .snd_addr(snd_addr),
      .snd_ack(snd_ack), .fork_req(fork_req), .fork_data(fork_data),
      .fork_ack(fork_ack), .end_req(end_req), .end_data(end_data),
      .end_ack(end_ack), .halted(halted), .err_flag(err_flag));

   always #(CLK_PERIOD/2) clk = ~clk;

   int unsigned cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_checks = 0, n_err = 0;
   logic [7:0]  prog [128];
   int          plen;
   logic [31:0] snd_d [16], snd_a [16];
   int          snd_hold [16];
   int          n_snd, n_fork, n_end, ack_wait, hold_s, hold_f, hold_e;
   logic [31:0] fork_d, end_d;
   int unsigned t0, t1;
   int          rdy_low;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // request responder: acknowledges after ack_wait extra cycles
   initial begin
      forever begin
         @(negedge clk);
         if (snd_ack) snd_ack = 1'b0;
         else if (snd_req) begin
            if (hold_s == ack_wait) begin
               if (n_snd < 16) begin
                  snd_d[n_snd] = snd_data; snd_a[n_snd] = snd_addr;
                  snd_hold[n_snd] = hold_s + 1;
               end
               n_snd++; hold_s = 0; snd_ack = 1'b1;
            end else hold_s++;
         end
         if (fork_ack) fork_ack = 1'b0;
         else if (fork_req) begin
            if (hold_f == ack_wait) begin
               fork_d = fork_data; n_fork++; hold_f = 0; fork_ack = 1'b1;
            end else hold_f++;
         end
         if (end_ack) end_ack = 1'b0;
         else if (end_req) begin
            if (hold_e == ack_wait) begin
               end_d = end_data; n_end++; hold_e = 0; end_ack = 1'b1;
            end else hold_e++;
         end
      end
   end

   task automatic do_reset();
      rst_n = 1'b0;
      msg_in_valid = 1'b0;
      n_snd = 0; n_fork = 0; n_end = 0; ack_wait = 0;
      hold_s = 0; hold_f = 0; hold_e = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic clear_prog();
      for (int i = 0; i < 128; i++) prog[i] = 8'h8A;  // move r2,r2
      plen = 0;
   endtask

   task automatic emit(input logic [7:0] b);
      prog[plen % 128] = b;
      plen++;
   endtask

   task automatic emit_imm(input logic [31:0] v);
      for (int i = 0; i < 4; i++) emit(v[8*i +: 8]);
   endtask

   task automatic send_msg(input logic [4:0] a, input logic [31:0] d, input logic st);
      @(negedge clk);
      msg_in_valid = 1'b1; msg_in_start = st; msg_in_addr = a; msg_in_data = d;
      while (!msg_in_ready) @(negedge clk);
      @(negedge clk);
      msg_in_valid = 1'b0; msg_in_start = 1'b0;
   endtask

   task automatic load_prog(input int nwords);
      for (int w = 0; w < nwords; w++)
         send_msg(5'(w), {prog[4*w+3], prog[4*w+2], prog[4*w+1], prog[4*w]}, 1'b0);
   endtask

   task automatic start_core();
      send_msg('0, '0, 1'b1);
      t0 = cyc;
   endtask

   task automatic wait_end(input int limit);
      int k = 0;
      rdy_low = 0;
      while (!end_req && k < limit) begin
         @(negedge clk);
         if (!msg_in_ready) rdy_low++;
         k++;
      end
      t1 = cyc;
      while (!halted && k < limit) begin @(negedge clk); k++; end
   endtask

   task automatic wait_snd(input int cnt, input int limit);
      int k = 0;
      while (n_snd < cnt && k < limit) begin @(negedge clk); k++; end
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 halted", 32'(halted), 32'd1);
      chk("R1 err_flag", 32'(err_flag), 32'd0);
      chk("R1 requests", 32'({snd_req, fork_req, end_req}), 32'd0);
      chk("R1 msg_in_ready", 32'(msg_in_ready), 32'd1);
   endtask

   task automatic t_alu();
      logic [31:0] exp_v [6];
      exp_v = '{32'h00000004, 32'h1FFFFFFE, 32'h10000001,
                32'hE0000002, 32'h20000002, 32'h48000000};
      do_reset(); clear_prog();
      emit(8'hB0); emit_imm(32'h00000055);            // fork #0x55
      emit(8'h90); emit_imm(32'h90000001);            // r0 = A
      emit(8'h94); emit_imm(32'h70000003);            // r1 = B
      emit(8'h88); emit(8'h09); emit(8'h68);          // add
      emit(8'h88); emit(8'h19); emit(8'h68);          // sub
      emit(8'h88); emit(8'h49); emit(8'h68);          // and
      emit(8'h88); emit(8'h59); emit(8'h68);          // xor
      emit(8'h2C); emit(8'h6C);                       // shl r3,r0
      emit(8'h3C); emit(8'h6C);                       // shr r3,r0
      emit(8'hC0); emit_imm(32'hCAFE0001);            // end
      load_prog((plen + 3) / 4);
      start_core();
      wait_end(2000);
      chk("R3 R4 snd count", 32'(n_snd), 32'd6);
      for (int i = 0; i < 6; i++) chk("R4 alu result", snd_d[i], exp_v[i]);
      chk("R7 snd_addr is reg2", snd_a[0], 32'h90000001);
      chk("R8 fork_data", fork_d, 32'h00000055);
      chk("R9 end_data", end_d, 32'hCAFE0001);
      chk("R6 cycles to end_req", t1 - t0, 32'd39);
      chk("R9 idle after end", 32'(halted), 32'd1);
   endtask

   task automatic t_ldst();
      do_reset(); clear_prog();
      send_msg(5'd25, 32'hDEADBEEF, 1'b0);
      emit(8'h90); emit_imm(32'h11223344);            // r0
      emit(8'h94); emit_imm(32'd100);                 // r1 = 100
      emit(8'hA1); emit_imm(32'd3);                   // store r0 -> [r1+3]
      emit(8'hD9); emit_imm(32'h80);                  // r2 <- [r1+128]
      emit(8'h69);                                    // snd r2,r1
      emit(8'hC0); emit_imm(32'h0);
      load_prog((plen + 3) / 4);
      start_core();
      wait_end(2000);
      chk("R5 load-memory after store", snd_d[0], 32'h11223344);
      chk("R5 load-immediate", snd_a[0], 32'd100);
      chk("R2 ready low cycles", 32'(rdy_low), 32'd2);
      chk("R6 cycles ldst", t1 - t0, 32'd11);
   endtask

   task automatic t_stall();
      do_reset(); clear_prog();
      emit(8'h60); emit(8'hC0); emit_imm(32'h0);
      load_prog(2);
      ack_wait = 5;
      start_core();
      wait_end(2000);
      chk("R7 stall length", t1 - t0, 32'd8);
      chk("R7 request held", 32'(snd_hold[0]), 32'd6);
      chk("R7 snd data", snd_d[0], 32'h0);
   endtask

   task automatic t_rcv();
      do_reset(); clear_prog();
      emit(8'h72); emit(8'h60); emit(8'h71); emit(8'h60);
      emit(8'h73); emit(8'h60); emit(8'hC0); emit_imm(32'h0);
      load_prog(3);
      start_core();
      for (int i = 0; i < 3; i++) send_msg(5'd30, 32'(i), 1'b0);
      repeat (10) @(negedge clk);
      chk("R10 two receives passed", 32'(n_snd), 32'd2);
      send_msg(5'd30, 32'h0, 1'b0);
      send_msg(5'd30, 32'h0, 1'b0);
      repeat (10) @(negedge clk);
      chk("R10 still waiting at two of three", 32'(n_snd), 32'd2);
      send_msg(5'd30, 32'h0, 1'b0);
      wait_end(200);
      chk("R10 third receive passed", 32'(n_snd), 32'd3);
   endtask

   task automatic t_illegal();
      do_reset(); clear_prog();
      emit(8'h90); emit_imm(32'd5); emit(8'hE0); emit(8'h60);
      load_prog(2);
      start_core();
      repeat (10) @(negedge clk);
      chk("R11 err_flag set", 32'(err_flag), 32'd1);
      chk("R11 halted", 32'(halted), 32'd1);
      chk("R11 nothing sent", 32'(n_snd), 32'd0);
      send_msg(5'd1, 32'h00C06000, 1'b0);             // byte5 snd, byte6 end
      start_core();
      chk("R11 start clears err", 32'(err_flag), 32'd0);
      wait_end(200);
      chk("R11 runs after restart", snd_d[0], 32'd5);
   endtask

   task automatic t_wrap();
      do_reset(); clear_prog();
      prog[4] = 8'h64;                                // snd r1,r0
      prog[5] = 8'h71;                                // rcv 1
      prog[127] = 8'h94;                              // load r1, imm from bytes 0..3
      load_prog(32);
      start_core();
      wait_snd(1, 200);
      chk("R12 first pass sends r1", snd_d[0], 32'h0);
      send_msg(5'd20, 32'h8A8A8A8A, 1'b0);
      wait_snd(2, 1000);
      chk("R12 sends after wrap", 32'(n_snd), 32'd2);
      chk("R12 immediate wrapped", snd_d[1], 32'h8A8A8A8A);
   endtask

   initial begin
      t_reset();
      t_alu();
      t_ldst();
      t_stall();
      t_rcv();
      t_illegal();
      t_wrap();
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      n_checks++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end
endmodule